// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Pin Interrupt

This block is a general-purpose I/O port with up to 32 pins, reached through a simple 32-bit slave bus. The bus carries a select, a write strobe, a byte address and write data. Reads are combinational from the address. Software sets each pin as a driven output or a sampled input. It reads the pins back and enables an interrupt for each pin with a mask. Pin events collect in a capture register, which software acknowledges by writing ones.

The interrupt behaviour is fixed by the `TRIGGER` parameter and software cannot change it. The settings are rising edge, falling edge, either edge, or level high. In the three edge settings, an edge seen on a synchronised input sets its capture bit, and the interrupt line is high while any captured bit is also enabled in the mask. In the level setting, nothing is captured and the interrupt comes straight from the masked data-register view.

Inputs pass through a two-stage synchroniser. A small settle machine then holds off edge detection after reset. Its states are SETTLE_A, SETTLE_B, SETTLE_C and LIVE, with the transitions SETTLE_A→SETTLE_B→SETTLE_C→LIVE, one per clock. LIVE holds until reset. While it settles, the synchroniser and the history flop fill with the real pin levels, so a pin held high through reset produces no capture.

Top module: `pin_port_irq`

## Requirements
- R1: Reset clears the direction, mask, output-latch and capture registers. While the port settles, `irq`, `pin_oe` and `pin_out` are all zero.
- R2: Direction bit 1 makes the pin an output: `pin_oe` equals the direction register and `pin_out` equals the output latch. A read of the data word returns the latch bit for outputs and the synchronised pin for inputs. Writing the data word updates the latch.
- R3: A change on `pin_in` shows in the data word after two rising clock edges, and not after one.
- R4: The word at byte offset 0x0 is data, 0x4 is direction, 0x8 is mask and 0xC is capture. Bits at or above `PIN_COUNT` read as 0. An access whose address bits [1:0] are not zero neither writes nor returns data; such a read gives 0.
- R5: In edge modes, the capture bit sets on the third rising clock edge after the pin changes. A 0→1 change sets it in rising mode, a 1→0 change sets it in falling mode, and either change sets it in both-edge mode.
- R6: A write to the capture word clears exactly the bits written as 1 and leaves the others unchanged.
- R7: If an edge is detected on a bit in the same cycle as a clearing write to that bit, the bit stays set.
- R8: In edge modes, `irq` is high exactly when some bit is set in both the capture and mask registers. A mask bit of 0 suppresses that pin.
- R9: In level mode, `irq` is high exactly when some bit is set in both the data word and the mask, and the capture word always reads 0.
- R10: For three clocks after reset, no edge is captured. A pin held high through reset therefore leaves its capture bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pin_in | input | PIN_COUNT | Pin levels from the pads |
| pin_out | output | PIN_COUNT | Output latch value toward the pads |
| pin_oe | output | PIN_COUNT | Output enable, one per pin |
| irq | output | 1 | Port interrupt |

## Verification
A detected edge and a software clear of the same capture bit can land in the same clock. To provoke this, the bench changes a pin and lets two clock edges pass. It then issues a capture write whose sampling edge is the edge on which the event registers. The written word also covers a second captured bit that has no event. The result passes if only the event bit survives and the other bit is cleared. All four trigger builds are also run against a shared vector table of pin patterns.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_MASK = 2'd2,
        REG_CAP  = 2'd3
    } reg_e;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge
    import pinport_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIGGER   = TRIG_BOTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] sync_o,
    output logic [PIN_COUNT-1:0] evt_o
);
    typedef enum logic [1:0] {
        SETTLE_A = 2'd0,
        SETTLE_B = 2'd1,
        SETTLE_C = 2'd2,
        LIVE     = 2'd3
    } settle_e;

    settle_e state_q, state_d;
    logic [PIN_COUNT-1:0] meta_q, sync_q, hist_q;
    logic [PIN_COUNT-1:0] rise, fall, raw;
    logic                 live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // settle machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SETTLE_A;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SETTLE_A: state_d = SETTLE_B;
            SETTLE_B: state_d = SETTLE_C;
            SETTLE_C: state_d = LIVE;
            LIVE:     state_d = LIVE;
        endcase
    end

    // settle machine: outputs
    always_comb begin
        live = 1'b0;
        unique case (state_q)
            SETTLE_A, SETTLE_B, SETTLE_C: live = 1'b0;
            LIVE:                         live = 1'b1;
        endcase
    end

    always_comb begin
        rise = sync_q & ~hist_q;
        fall = ~sync_q & hist_q;
        unique case (TRIGGER)
            TRIG_RISE:  raw = rise;
            TRIG_FALL:  raw = fall;
            TRIG_BOTH:  raw = rise | fall;
            TRIG_LEVEL: raw = '0;
        endcase
    end

    assign sync_o = sync_q;
    assign evt_o  = live ? raw : '0;

    // R3: two-flop latency from pad to synchronised view
    p_sync_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LIVE) |-> (sync_q == $past(pin_in, 2)));

    // R10: no edge reported while settling
    p_settle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LIVE) |-> (evt_o == '0));
endmodule

// File: rtl/pin_capture.sv
module pin_capture
    import pinport_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIGGER   = TRIG_BOTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] evt_i,
    input  logic [PIN_COUNT-1:0] clr_i,
    output logic [PIN_COUNT-1:0] cap_o
);
    logic [PIN_COUNT-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_i) | evt_i;
    end

    assign cap_o = cap_q;

    // R6: a clear with no coincident event empties the bit
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~evt_i) != '0) |=> ((cap_q & $past(clr_i & ~evt_i)) == '0));

    // R7: an event always lands, even against a clear
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((cap_q & $past(evt_i)) == $past(evt_i)));

    generate
        if (TRIGGER == TRIG_LEVEL) begin : g_lvl_chk
            // R9: nothing captured in level mode
            p_cap_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
                cap_q == '0);
        end
    endgenerate
endmodule

// File: rtl/pin_irq_gen.sv
module pin_irq_gen
    import pinport_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIGGER   = TRIG_BOTH
) (
    input  logic [PIN_COUNT-1:0] cap_i,
    input  logic [PIN_COUNT-1:0] data_i,
    input  logic [PIN_COUNT-1:0] mask_i,
    output logic                 irq_o
);
    localparam bit USE_LEVEL = (TRIGGER == TRIG_LEVEL);

    logic [PIN_COUNT-1:0] src;

    assign src   = USE_LEVEL ? data_i : cap_i;
    assign irq_o = |(src & mask_i);
endmodule

// File: rtl/pin_port_irq.sv
module pin_port_irq
    import pinport_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIGGER   = TRIG_BOTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);
    logic [PIN_COUNT-1:0] out_q, dir_q, mask_q;
    logic [PIN_COUNT-1:0] sync_v, evt_v, cap_v, clr_v, data_view;
    logic                 aligned, wr_en;
    reg_e                 idx;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = reg_e'(bus_addr[3:2]);
    assign wr_en   = bus_sel & bus_wr & aligned;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            unique case (idx)
                REG_DATA: out_q  <= bus_wdata[PIN_COUNT-1:0];
                REG_DIR:  dir_q  <= bus_wdata[PIN_COUNT-1:0];
                REG_MASK: mask_q <= bus_wdata[PIN_COUNT-1:0];
                REG_CAP:  ;
            endcase
        end
    end

    assign clr_v     = (wr_en && idx == REG_CAP) ? bus_wdata[PIN_COUNT-1:0] : '0;
    assign data_view = (dir_q & out_q) | (~dir_q & sync_v);

    always_comb begin
        logic [PIN_COUNT-1:0] sel;
        sel = '0;
        unique case (idx)
            REG_DATA: sel = data_view;
            REG_DIR:  sel = dir_q;
            REG_MASK: sel = mask_q;
            REG_CAP:  sel = cap_v;
        endcase
        bus_rdata = '0;
        if (aligned) bus_rdata[PIN_COUNT-1:0] = sel;
    end

    pin_sync_edge #(.PIN_COUNT(PIN_COUNT), .TRIGGER(TRIGGER)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_o (sync_v),
        .evt_o  (evt_v)
    );

    pin_capture #(.PIN_COUNT(PIN_COUNT), .TRIGGER(TRIGGER)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_v),
        .clr_i (clr_v),
        .cap_o (cap_v)
    );

    pin_irq_gen #(.PIN_COUNT(PIN_COUNT), .TRIGGER(TRIGGER)) u_irq (
        .cap_i  (cap_v),
        .data_i (data_view),
        .mask_i (mask_q),
        .irq_o  (irq)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    // R2: the enable follows a direction write
    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_DIR) |=> (pin_oe == $past(bus_wdata[PIN_COUNT-1:0])));

    // R8/R9: no interrupt with every pin masked
    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

    // R4: a misaligned write leaves direction untouched
    p_misaligned_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !aligned) |=> $stable(pin_oe));
endmodule

// File: tb/pin_port_irq_tb.sv
module pin_port_irq_tb;
    import pinport_pkg::*;

    localparam int NP = 12;
    localparam int NL = 8;
    localparam logic [NP-1:0] ALLP = '1;

    logic clk = 1'b0;
    logic rst_n, bus_sel, bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [NP-1:0] pins;

    logic [31:0] rd_b, rd_r, rd_f, rd_l;
    logic [NP-1:0] out_b, oe_b, out_r, oe_r, out_f, oe_f;
    logic [NL-1:0] out_l, oe_l;
    logic irq_b, irq_r, irq_f, irq_l;

    logic [31:0] v_b, v_r, v_f, v_l;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_port_irq #(.PIN_COUNT(NP), .TRIGGER(TRIG_BOTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .pin_in(pins), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));
    pin_port_irq #(.PIN_COUNT(NP), .TRIGGER(TRIG_RISE)) u_rise (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_r),
        .pin_in(pins), .pin_out(out_r), .pin_oe(oe_r), .irq(irq_r));
    pin_port_irq #(.PIN_COUNT(NP), .TRIGGER(TRIG_FALL)) u_fall (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_f),
        .pin_in(pins), .pin_out(out_f), .pin_oe(oe_f), .irq(irq_f));
    pin_port_irq #(.PIN_COUNT(NL), .TRIGGER(TRIG_LEVEL)) u_lvl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_l),
        .pin_in(pins[NL-1:0]), .pin_out(out_l), .pin_oe(oe_l), .irq(irq_l));

    // pin pattern and both-edge capture expected after it
    localparam int NV = 6;
    localparam logic [NP-1:0] VEC_PIN [NV] = '{12'h005, 12'h00F, 12'h800, 12'hFFF, 12'h0F0, 12'h000};
    localparam logic [NP-1:0] VEC_CAP [NV] = '{12'h005, 12'h00A, 12'h80F, 12'h7FF, 12'hF0F, 12'h0F0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v_b = rd_b; v_r = rd_r; v_f = rd_f; v_l = rd_l;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] prev;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pins = 12'h003;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 pin_oe", 32'(oe_b), 0);
        chk("R1 pin_out", 32'(out_b), 0);
        chk("R1 irq", 32'(irq_b | irq_l), 0);
        rd(4'h4); chk("R1 dir", v_b, 0);
        rd(4'h8); chk("R1 mask", v_b, 0);

        // R10: pins high through reset leave no capture
        repeat (6) @(posedge clk);
        rd(4'hC); chk("R10 cap both", v_b, 0); chk("R10 cap rise", v_r, 0);
        rd(4'h0); chk("R3 data after settle", v_b, 32'h003);

        // R5: falling edges after settle
        @(negedge clk); pins = 12'h000;
        repeat (3) @(posedge clk);
        rd(4'hC);
        chk("R5 fall mode", v_f, 32'h003);
        chk("R5 rise mode ignores fall", v_r, 0);
        chk("R5 both mode", v_b, 32'h003);
        wr(4'hC, 32'hFFF);
        rd(4'hC); chk("R6 clear all", v_b | v_f, 0);

        // table walk
        wr(4'h8, 32'hFFF);
        prev = '0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); pins = VEC_PIN[i];
            repeat (3) @(posedge clk);
            rd(4'h0); chk("R3 data view", v_b, 32'(VEC_PIN[i]));
            rd(4'hC);
            chk("R5 both", v_b, 32'(VEC_CAP[i]));
            chk("R5 rise", v_r, 32'(VEC_PIN[i] & ~prev));
            chk("R5 fall", v_f, 32'(~VEC_PIN[i] & prev & ALLP));
            chk("R9 cap zero", v_l, 0);
            chk("R8 irq edge", 32'(irq_b), 32'(VEC_CAP[i] != 0));
            chk("R9 irq level", 32'(irq_l), 32'(VEC_PIN[i][NL-1:0] != 0));
            wr(4'hC, 32'hFFF);
            chk("R8 irq after clear", 32'(irq_b), 0);
            prev = VEC_PIN[i];
        end

        // R8: mask gates the interrupt
        @(negedge clk); pins = 12'h001;
        repeat (3) @(posedge clk);
        wr(4'h8, 32'h000);
        chk("R8 masked irq", 32'(irq_b), 0);
        rd(4'hC); chk("R8 cap held", v_b, 32'h001);
        wr(4'h8, 32'h001); chk("R8 unmasked irq", 32'(irq_b), 1);
        wr(4'h8, 32'h002); chk("R8 other mask", 32'(irq_b), 0);
        wr(4'h8, 32'hFFF);
        wr(4'hC, 32'hFFF);

        // R6: partial clear
        @(negedge clk); pins = 12'h00E;
        repeat (3) @(posedge clk);
        rd(4'hC); chk("R6 setup", v_b, 32'h00F);
        wr(4'hC, 32'h005);
        rd(4'hC); chk("R6 partial clear", v_b, 32'h00A);

        // R7: edge coincident with clear of the same bit
        @(negedge clk); pins = 12'h00C;
        @(posedge clk);
        @(posedge clk);
        wr(4'hC, 32'h00A);
        rd(4'hC); chk("R7 edge wins", v_b, 32'h002);
        wr(4'hC, 32'hFFF);

        // R2: direction and output latch
        @(negedge clk); pins = 12'h000;
        repeat (3) @(posedge clk);
        chk("R9 level idle", 32'(irq_l), 0);
        wr(4'h0, 32'h0A5);
        rd(4'h0); chk("R2 input view", v_b, 0);
        chk("R9 latch not seen as input", 32'(irq_l), 0);
        wr(4'h4, 32'h0F0);
        chk("R2 pin_oe", 32'(oe_b), 32'h0F0);
        chk("R2 pin_out", 32'(out_b), 32'h0A5);
        @(negedge clk); pins = 12'h00C;
        repeat (3) @(posedge clk);
        rd(4'h0); chk("R2 mixed view", v_b, 32'h0AC);
        chk("R9 level from output latch", 32'(irq_l), 1);

        // R4: map width and alignment
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4); chk("R4 dir width", v_b, 32'hFFF); chk("R4 level width", v_l, 32'hFF);
        wr(4'h5, 32'h0);
        rd(4'h4); chk("R4 misaligned write", v_b, 32'hFFF);
        rd(4'h9); chk("R4 misaligned read", v_b, 0);
        rd(4'h8); chk("R4 mask readback", v_b, 32'hFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule